// File: doc/BRIEF.md
# Critical Section Offload Request Queue

This block sits beside a large core and gathers requests from several small cores that want a critical section run on the large core. Each request carries the lock address, the target program counter, the stack pointer and the requesting core's index. Accepted requests wait in a first-come-first-served queue. The block hands exactly one of them at a time to the large core. The requesting core stalls until it gets an answer.

When the large core finishes a section, it reports a return tagged with the lock address. The block then pulses a done response on the channel of the core that owns the section. A bank of small saturating counters, selected by the low bits of the lock address, watches for independent sections that queue behind a different lock. When a lock's counter is full, a new request for that lock is not queued. The requester instead gets a run-locally response and executes the section itself.

Top module: `cs_offload_queue`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `exe_vld`, `done_vld` and `local_vld` are all zero.
- R2: If the block is idle and a request is sampled at a clock edge, `exe_vld` rises at the next edge. `exe_core`, `exe_lock`, `exe_pc` and `exe_sp` then equal the request's fields.
- R3: Queued requests are handed to the large core strictly in the order they were sampled.
- R4: Only one section runs at a time. While `exe_vld` is high, the `exe_*` fields hold. The next dispatch happens at the edge after the edge that sampled the matching return.
- R5: A return whose `ret_lock` equals `exe_lock` while `exe_vld` is high does three things at that edge. It drops `exe_vld`. It raises bit `c` of `done_vld` for exactly one cycle, with `c` the running core's index. It sets `done_core` to `c`.
- R6: A return whose lock differs from the running section's lock has no effect: `exe_vld` stays high and no done pulse appears.
- R7: Each lock maps to the counter at index `lock[LKB-1:0]`. At each dispatch that counter moves by one. It goes up (saturating at 2^CNTW-1) if any request with a different lock address is still queued, and down (stopping at 0) otherwise.
- R8: A request whose counter is at its maximum when sampled is not queued. Bit `c` of `local_vld` pulses for one cycle at that edge, with `local_core` equal to `c`, and the counter is decremented by one.
- R9: After such a refusal has lowered the counter below its maximum, a later request for the same lock is queued and dispatched normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | A small core presents a request this cycle |
| req_core | input | CW | Index of the requesting core |
| req_lock | input | AW | Lock address of the section |
| req_pc | input | PCW | Target program counter |
| req_sp | input | SPW | Stack pointer of the requester |
| exe_vld | output | 1 | A section is handed to the large core |
| exe_core | output | CW | Owner of the running section |
| exe_lock | output | AW | Lock of the running section |
| exe_pc | output | PCW | Target program counter of the running section |
| exe_sp | output | SPW | Stack pointer of the running section |
| ret_vld | input | 1 | Large core reports a finished section |
| ret_lock | input | AW | Lock address carried by the return |
| done_vld | output | NCORE | One-hot done pulse per core |
| done_core | output | CW | Core index of the done pulse |
| local_vld | output | NCORE | One-hot run-locally pulse per core |
| local_core | output | CW | Core index of the run-locally pulse |

## Verification
Every output is a register. A done or run-locally pulse therefore appears right after the edge that samples the return or the refused request. A dispatch appears one edge after the request is sampled, or one edge after the edge that sampled the previous section's return. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so each table row holds the outputs due after the rising edge that consumed that row's inputs. The counter values behind the expected refusals were worked out row by row from the counter rules.

// File: rtl/cs_offload_queue.sv
module cs_offload_queue #(
  parameter int NCORE = 4,
  parameter int AW    = 8,
  parameter int PCW   = 16,
  parameter int SPW   = 16,
  parameter int LKB   = 2,
  parameter int CNTW  = 2,
  localparam int CW   = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_vld,
  input  logic [CW-1:0]    req_core,
  input  logic [AW-1:0]    req_lock,
  input  logic [PCW-1:0]   req_pc,
  input  logic [SPW-1:0]   req_sp,
  output logic             exe_vld,
  output logic [CW-1:0]    exe_core,
  output logic [AW-1:0]    exe_lock,
  output logic [PCW-1:0]   exe_pc,
  output logic [SPW-1:0]   exe_sp,
  input  logic             ret_vld,
  input  logic [AW-1:0]    ret_lock,
  output logic [NCORE-1:0] done_vld,
  output logic [CW-1:0]    done_core,
  output logic [NCORE-1:0] local_vld,
  output logic [CW-1:0]    local_core
);
  localparam int NLK  = 1 << LKB;
  localparam int CMAX = (1 << CNTW) - 1;
  localparam int QW   = CW + 1;

  logic [AW-1:0]   q_lock [NCORE];
  logic [PCW-1:0]  q_pc   [NCORE];
  logic [SPW-1:0]  q_sp   [NCORE];
  logic [CW-1:0]   q_core [NCORE];
  logic [CW-1:0]   rd_p, wr_p;
  logic [QW-1:0]   q_cnt;
  logic [CNTW-1:0] sat    [NLK];
  logic [CNTW-1:0] sat_nx [NLK];
  logic            others;

  function automatic logic [CW-1:0] nxt(input logic [CW-1:0] p);
    return (p == CW'(NCORE - 1)) ? '0 : p + 1'b1;
  endfunction

  wire [LKB-1:0] req_idx = req_lock[LKB-1:0];
  wire [LKB-1:0] pop_idx = q_lock[rd_p][LKB-1:0];
  wire refuse = req_vld && (sat[req_idx] == CNTW'(CMAX));
  wire push   = req_vld && !refuse;
  wire pop    = !exe_vld && (q_cnt != '0);
  wire finish = exe_vld && ret_vld && (ret_lock == exe_lock);

  always_comb begin
    others = 1'b0;
    for (int i = 1; i < NCORE; i++) begin
      if (QW'(i) < q_cnt && q_lock[CW'((int'(rd_p) + i) % NCORE)] != q_lock[rd_p])
        others = 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < NLK; i++) begin
      int v;
      v = int'(sat[i]);
      if (pop && pop_idx == LKB'(i)) v = others ? v + 1 : v - 1;
      if (refuse && req_idx == LKB'(i)) v = v - 1;
      if (v < 0) v = 0;
      if (v > CMAX) v = CMAX;
      sat_nx[i] = CNTW'(v);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_p <= '0; wr_p <= '0; q_cnt <= '0;
      exe_vld <= 1'b0; done_vld <= '0; local_vld <= '0;
      exe_core <= '0; exe_lock <= '0; exe_pc <= '0; exe_sp <= '0;
      done_core <= '0; local_core <= '0;
      for (int i = 0; i < NLK; i++) sat[i] <= '0;
    end else begin
      for (int i = 0; i < NLK; i++) sat[i] <= sat_nx[i];
      if (push) begin
        q_lock[wr_p] <= req_lock; q_pc[wr_p] <= req_pc;
        q_sp[wr_p]   <= req_sp;   q_core[wr_p] <= req_core;
        wr_p <= nxt(wr_p);
      end
      if (pop) begin
        exe_vld  <= 1'b1;
        exe_core <= q_core[rd_p]; exe_lock <= q_lock[rd_p];
        exe_pc   <= q_pc[rd_p];   exe_sp   <= q_sp[rd_p];
        rd_p <= nxt(rd_p);
      end else if (finish) begin
        exe_vld <= 1'b0;
      end
      q_cnt <= q_cnt + QW'(push) - QW'(pop);
      done_vld   <= finish ? (NCORE'(1) << exe_core) : '0;
      done_core  <= exe_core;
      local_vld  <= refuse ? (NCORE'(1) << req_core) : '0;
      local_core <= req_core;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (q_cnt < QW'(NCORE) || pop)); // R3
  AST_EXE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_vld && $past(exe_vld)) |-> ($stable(exe_core) && $stable(exe_lock))); // R4
  AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_vld)); // R5
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_vld) |-> $past(ret_vld && exe_vld && ret_lock == exe_lock)); // R6
  AST_LOCAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|local_vld) |-> ($past(req_vld) && $onehot(local_vld))); // R8
endmodule

// File: tb/sim_cs_offload_queue.sv
`timescale 1ns/1ps
module sim_cs_offload_queue;
  localparam int NC = 4;
  localparam logic [7:0] LA = 8'h11;
  localparam logic [7:0] LB = 8'h22;
  localparam int NROW = 25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_vld = 1'b0, ret_vld = 1'b0;
  logic [1:0] req_core = '0;
  logic [7:0] req_lock = '0, ret_lock = '0;
  logic [15:0] req_pc = '0, req_sp = '0;
  logic exe_vld;
  logic [1:0] exe_core, done_core, local_core;
  logic [7:0] exe_lock;
  logic [15:0] exe_pc, exe_sp;
  logic [3:0] done_vld, local_vld;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cs_offload_queue u0 (.clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_core(req_core),
    .req_lock(req_lock), .req_pc(req_pc), .req_sp(req_sp), .exe_vld(exe_vld),
    .exe_core(exe_core), .exe_lock(exe_lock), .exe_pc(exe_pc), .exe_sp(exe_sp),
    .ret_vld(ret_vld), .ret_lock(ret_lock), .done_vld(done_vld), .done_core(done_core),
    .local_vld(local_vld), .local_core(local_core));

  function automatic logic [30:0] row(bit rq, logic [1:0] rc, logic [7:0] rl, bit rt,
      logic [7:0] rtl, bit ee, logic [1:0] ec, logic [3:0] ed, logic [3:0] el);
    return {rq, rc, rl, rt, rtl, ee, ec, ed, el};
  endfunction

  localparam logic [30:0] TBL [NROW] = '{
    row(1,0,LA,0,0, 0,0,4'h0,4'h0),
    row(1,1,LB,0,0, 1,0,4'h0,4'h0),
    row(1,2,LA,0,0, 1,0,4'h0,4'h0),
    row(1,3,LB,0,0, 1,0,4'h0,4'h0),
    row(0,0,0,1,LA, 0,0,4'h1,4'h0),
    row(0,0,0,0,0,  1,1,4'h0,4'h0),
    row(1,0,LA,0,0, 1,1,4'h0,4'h0),
    row(0,0,0,1,LB, 0,0,4'h2,4'h0),
    row(0,0,0,0,0,  1,2,4'h0,4'h0),
    row(0,0,0,1,LA, 0,0,4'h4,4'h0),
    row(1,1,LB,0,0, 1,3,4'h0,4'h0),
    row(1,2,LA,0,0, 1,3,4'h0,4'h0),
    row(0,0,0,1,LB, 0,0,4'h8,4'h0),
    row(0,0,0,0,0,  1,0,4'h0,4'h0),
    row(0,0,0,1,LA, 0,0,4'h1,4'h0),
    row(0,0,0,0,0,  1,1,4'h0,4'h0),
    row(1,3,LB,0,0, 1,1,4'h0,4'h8),
    row(0,0,0,1,LB, 0,0,4'h2,4'h0),
    row(0,0,0,0,0,  1,2,4'h0,4'h0),
    row(1,3,LB,0,0, 1,2,4'h0,4'h0),
    row(0,0,0,1,LB, 1,2,4'h0,4'h0),
    row(0,0,0,1,LA, 0,0,4'h4,4'h0),
    row(0,0,0,0,0,  1,3,4'h0,4'h0),
    row(0,0,0,1,LB, 0,0,4'h8,4'h0),
    row(0,0,0,0,0,  0,0,4'h0,4'h0)
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] enc(input logic [3:0] oh);
    logic [1:0] r = '0;
    for (int i = 0; i < NC; i++) if (oh[i]) r = 2'(i);
    return r;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(exe_vld == 0 && done_vld == 0 && local_vld == 0, "R1 reset outputs",
        {exe_vld, done_vld, local_vld}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(exe_vld == 0 && done_vld == 0 && local_vld == 0, "R1 after reset",
        {exe_vld, done_vld, local_vld}, 0);
    // Table: FCFS order, one-at-a-time, done routing, saturation at row 16 (R7 R8),
    // mismatched return at row 20 (R6), re-queue of lock B at row 19 (R9)
    for (int k = 0; k < NROW; k++) begin
      automatic logic [30:0] v = TBL[k];
      req_vld = v[30]; req_core = v[29:28]; req_lock = v[27:20];
      req_pc = {8'hC0, v[27:20]}; req_sp = {14'h0, v[29:28]};
      ret_vld = v[19]; ret_lock = v[18:11];
      @(negedge clk);
      chk(exe_vld == v[10], $sformatf("R2 R3 R4 exe_vld row %0d", k), exe_vld, v[10]);
      if (v[10]) chk(exe_core == v[9:8], $sformatf("R3 R4 exe_core row %0d", k), exe_core, v[9:8]);
      chk(done_vld == v[7:4], $sformatf("R5 R6 done_vld row %0d", k), done_vld, v[7:4]);
      if (v[7:4] != 0) chk(done_core == enc(v[7:4]), $sformatf("R5 done_core row %0d", k), done_core, enc(v[7:4]));
      chk(local_vld == v[3:0], $sformatf("R7 R8 R9 local_vld row %0d", k), local_vld, v[3:0]);
      if (v[3:0] != 0) chk(local_core == enc(v[3:0]), $sformatf("R8 local_core row %0d", k), local_core, enc(v[3:0]));
    end
    req_vld = 0; ret_vld = 0;
    // Directed: payload carried unchanged (R2)
    @(negedge clk);
    req_vld = 1; req_core = 2; req_lock = 8'h5A; req_pc = 16'hBEEF; req_sp = 16'h1234;
    @(negedge clk);
    req_vld = 0;
    chk(exe_vld == 0, "R2 not yet dispatched", exe_vld, 0);
    @(negedge clk);
    chk(exe_vld == 1 && exe_core == 2, "R2 dispatch core", {exe_vld, exe_core}, {1'b1, 2'd2});
    chk(exe_lock == 8'h5A, "R2 lock", exe_lock, 8'h5A);
    chk(exe_pc == 16'hBEEF && exe_sp == 16'h1234, "R2 pc sp", {exe_pc, exe_sp}, 32'hBEEF1234);
    ret_vld = 1; ret_lock = 8'h5A;
    @(negedge clk);
    ret_vld = 0;
    chk(done_vld == 4'b0100 && done_core == 2, "R5 done to core 2", {done_vld, done_core}, {4'b0100, 2'd2});
    @(negedge clk);
    chk(done_vld == 0 && exe_vld == 0, "R5 single pulse", {done_vld, exe_vld}, 0);
    // Directed: reset in mid-run (R1)
    req_vld = 1; req_core = 1; req_lock = LA;
    @(negedge clk);
    req_vld = 0;
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(exe_vld == 0 && done_vld == 0 && local_vld == 0, "R1 reset mid-run",
        {exe_vld, done_vld, local_vld}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(exe_vld == 0, "R1 queue emptied by reset", exe_vld, 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule